// File: doc/BRIEF.md
# Iterative Sign-Magnitude Power-of-Two Shifter

This unit multiplies or divides an unsigned N-bit operand by a power of two. It does this with a logical shift of one bit position per clock. The shift amount arrives as a magnitude plus a separate direction bit, which is the sign of the exponent. Any bit pushed out of the word is lost, and the vacated end is always filled with zero.

The unit is started by holding the synchronous active-low reset. While reset is held, the operand, the magnitude and the direction are captured and the completion flag is cleared. After reset is released, every clock moves the working word one place and lowers the remaining count by one. The cycle after the count reaches zero raises the completion flag. From then on the result and the count stay frozen until the next reset.

The remaining count is visible on a port, so a caller can follow progress. An operand of width N finishes a magnitude of E exactly E+1 clocks after reset is released.

Top module: `shf_iter`

## Requirements
- R1: A clock edge with `rst_n` low loads `result_o` with `operand_i`, loads `remaining_o` with `amount_i` and clears `done_o`.
- R2: With direction 0 (`dir_i` = 0 at reset) each working cycle moves `result_o` one place toward the MSB, inserting 0 at bit 0 and dropping the old MSB.
- R3: With direction 1 each working cycle moves `result_o` one place toward bit 0, inserting 0 at the MSB and dropping the old bit 0.
- R4: A working cycle is a clock with `remaining_o` > 0 and `done_o` low. In each working cycle `remaining_o` drops by exactly one, and it never wraps below zero.
- R5: The clock after `remaining_o` reaches zero with `done_o` low raises `done_o`. For a magnitude E, `done_o` rises on the (E+1)-th edge after reset release, and `done_o` is high only while `remaining_o` is zero.
- R6: Once `done_o` is high, `done_o`, `result_o` and `remaining_o` hold their values until the next reset.
- R7: A magnitude of zero leaves `result_o` equal to the operand and raises `done_o` one clock after reset release.
- R8: A magnitude of N or more yields an all-zero result.
- R9: The direction is taken only at reset. Changing `dir_i` while the unit works has no effect on the result.
- R10: With N = 14 and operand 01110111010010, magnitude 5 with direction 0 gives 11101001000000, and with direction 1 gives 00000011101110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also the load strobe |
| operand_i | input | N | Unsigned value to scale |
| amount_i | input | CW | Shift magnitude |
| dir_i | input | 1 | Direction: 0 = toward MSB (multiply), 1 = toward LSB (divide) |
| result_o | output | N | Working word and final result |
| remaining_o | output | CW | Shifts still to perform |
| done_o | output | 1 | Completion flag |

## Verification
The hardest case to reach is the direction input changing in the middle of a run. A correct design ignores it, because the direction is held in a register and no result shows where it is taken from. The bench therefore re-runs selected operands with `dir_i` inverted right after reset is released, and compares every intermediate result against the direction applied at reset. Magnitudes that exceed the width drive the word to zero before the count expires. A few directed runs cover these along with zero magnitude, the largest magnitude and the known vectors; random runs fill in the rest.

// File: rtl/shf_pkg.sv
// Package shf_pkg
// Shared types for the iterative shifter. Assumes nothing beyond IEEE 1800-2017.
package shf_pkg;
    // Direction encoding: value of the direction bit captured at reset.
    typedef enum logic {
        SHF_LEFT  = 1'b0,
        SHF_RIGHT = 1'b1
    } shf_dir_e;
endpackage

// File: rtl/shf_count.sv
// Module shf_count
// Down-counter and completion flag. Loads the magnitude and clears the flag
// while rst_n is low. Afterwards it counts down to zero without wrapping, then
// sets the flag and freezes. Assumes a synchronous active-low reset.
module shf_count #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] load_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o,
    output logic          step_o
);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_ZERO = '0;

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // A working cycle: count still positive and flag low.
    assign step_o = (cnt_q != CNT_ZERO) && !done_q;

    // Load on reset, count down while working, then latch the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= load_i;
            done_q <= 1'b0;
        end else if (step_o) begin
            cnt_q  <= cnt_q - CNT_ONE;
        end else begin
            done_q <= 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = done_q;

    // R4: a working cycle lowers the count by exactly one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_ZERO && !done_q) |=> (cnt_q == $past(cnt_q) - CNT_ONE) && !done_q);
    // R5: reaching zero with flag low raises the flag next clock
    a_r5_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_ZERO && !done_q) |=> done_q);
    // R5: flag only while the count is zero
    a_r5_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> cnt_q == CNT_ZERO);
    // R6: flag and count frozen once done
    a_r6_count_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q && $stable(cnt_q));
    // R1: reset loads the magnitude and clears the flag
    a_r1_count_load: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == $past(load_i)) && !done_q);
endmodule

// File: rtl/shf_datapath.sv
// Module shf_datapath
// Working register and direction register. Loads the operand and direction on
// reset. On each enabled cycle it moves the word one place, zero-filled. A
// bit-slice generate gives each bit its own two-way source select.
// Assumes the enable is low during reset.
module shf_datapath
    import shf_pkg::*;
#(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] op_i,
    input  logic         dir_i,
    input  logic         en_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q;
    logic [N-1:0] q_nx;
    shf_dir_e     dir_q;

    // Per-bit source: neighbour below for left moves, neighbour above for right moves.
    for (genvar i = 0; i < N; i++) begin : g_slice
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lsb
            assign from_lo = 1'b0;
        end else begin : g_lo
            assign from_lo = q[i-1];
        end
        if (i == N-1) begin : g_msb
            assign from_hi = 1'b0;
        end else begin : g_hi
            assign from_hi = q[i+1];
        end
        assign q_nx[i] = (dir_q == SHF_RIGHT) ? from_hi : from_lo;
    end

    // Capture direction and operand on reset; move when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= op_i;
            dir_q <= shf_dir_e'(dir_i);
        end else if (en_i) begin
            q     <= q_nx;
        end
    end

    assign q_o = q;

    // R2: left move inserts zero at bit 0
    a_r2_left_move: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dir_q == SHF_LEFT) |=> q == {$past(q[N-2:0]), 1'b0});
    // R3: right move inserts zero at the MSB
    a_r3_right_move: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dir_q == SHF_RIGHT) |=> q == {1'b0, $past(q[N-1:1])});
    // R6: word held when not working
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q));
    // R9: direction fixed between resets
    a_r9_dir_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(dir_q));
    // R1: reset loads the operand
    a_r1_word_load: assert property (@(posedge clk)
        !rst_n |=> q == $past(op_i));
endmodule

// File: rtl/shf_iter.sv
// Module shf_iter
// Top of the iterative sign-magnitude shifter. Holding rst_n low loads the
// operand, magnitude and direction. After release, one bit position is moved
// per clock until the count runs out, then done_o rises and everything holds.
// Assumes the caller keeps rst_n low for at least one rising edge per run.
module shf_iter #(
    parameter int N  = 14,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  operand_i,
    input  logic [CW-1:0] amount_i,
    input  logic          dir_i,
    output logic [N-1:0]  result_o,
    output logic [CW-1:0] remaining_o,
    output logic          done_o
);
    logic step;

    // Sequencing: counter and completion flag.
    shf_count #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (amount_i),
        .cnt_o  (remaining_o),
        .done_o (done_o),
        .step_o (step)
    );

    // Data: working word and direction.
    shf_datapath #(.N(N)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (operand_i),
        .dir_i (dir_i),
        .en_i  (step),
        .q_o   (result_o)
    );

    // R6: result frozen once done across the two sub-blocks
    a_r6_result_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(result_o));
endmodule

// File: tb/shf_iter_bench.sv
// Bench for shf_iter: directed corners plus seeded random runs, every cycle
// compared against a bench-side model of the requirements.
module shf_iter_bench;
    localparam int N  = 14;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  operand = '0;
    logic [CW-1:0] amount = '0;
    logic          dir = 1'b0;
    logic [N-1:0]  result;
    logic [CW-1:0] remaining;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    shf_iter #(.N(N), .CW(CW)) u_shf_iter (
        .clk         (clk),
        .rst_n       (rst_n),
        .operand_i   (operand),
        .amount_i    (amount),
        .dir_i       (dir),
        .result_o    (result),
        .remaining_o (remaining),
        .done_o      (done)
    );

    // Model: zero-filled shift by amt positions.
    function automatic logic [N-1:0] model_shift(logic [N-1:0] x, int amt, bit right);
        logic [N-1:0] v = x;
        for (int i = 0; i < amt; i++) v = right ? (v >> 1) : (v << 1);
        return v;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One run: reset load, then every cycle checked, plus three held cycles.
    task automatic run_case(logic [N-1:0] x, int e, bit right, bit flip);
        int k;
        int eff;
        @(negedge clk);
        operand = x; amount = CW'(e); dir = right; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(result == x, "R1 result load", result, x);
        chk(remaining == CW'(e), "R1 count load", remaining, e);
        chk(done == 1'b0, "R1 done clear", done, 0);
        rst_n = 1'b1;
        if (flip) dir = ~right;   // R9: must not matter
        for (k = 1; k <= e + 3; k++) begin
            @(posedge clk); @(negedge clk);
            eff = (k < e) ? k : e;
            chk(result == model_shift(x, eff, right),
                (k > e) ? "R6 result hold" : (flip ? "R9 dir ignored" : (right ? "R3 right move" : "R2 left move")),
                result, model_shift(x, eff, right));
            chk(remaining == CW'(e - eff), "R4 count step", remaining, e - eff);
            chk(done == (k >= e + 1), (e == 0) ? "R7 zero magnitude done" : "R5 done timing",
                done, (k >= e + 1));
        end
        if (e == 0) chk(result == x, "R7 zero magnitude result", result, x);
        if (e >= N) chk(result == '0, "R8 oversize gives zero", result, 0);
    endtask

    initial begin : stim
        logic [N-1:0] rx;
        int re;
        void'($urandom(32'd20240607));
        repeat (2) @(posedge clk);
        // R10: known vectors
        run_case(14'b01110111010010, 5, 1'b0, 1'b0);
        chk(result == 14'b11101001000000, "R10 left vector", result, 14'b11101001000000);
        run_case(14'b01110111010010, 5, 1'b1, 1'b0);
        chk(result == 14'b00000011101110, "R10 right vector", result, 14'b00000011101110);
        // R7, R8 corners
        run_case(14'h3fff, 0, 1'b0, 1'b0);
        run_case(14'h2a5b, 0, 1'b1, 1'b0);
        run_case(14'h3fff, N, 1'b0, 1'b0);
        run_case(14'h3fff, N, 1'b1, 1'b0);
        run_case(14'h1234, (1 << CW) - 1, 1'b1, 1'b0);
        run_case(14'h2001, N - 1, 1'b0, 1'b0);
        run_case(14'h2001, N - 1, 1'b1, 1'b0);
        // R9: direction flipped mid-run
        run_case(14'h1b3c, 4, 1'b0, 1'b1);
        run_case(14'h1b3c, 4, 1'b1, 1'b1);
        // Random runs
        for (int i = 0; i < 40; i++) begin
            rx = N'($urandom);
            re = int'($urandom % (1 << CW));
            run_case(rx, re, bit'($urandom % 2), bit'($urandom % 4 == 0));
        end
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule